// File: doc/BRIEF.md
# Reference Clock Loss Power-Down Monitor

This block decides whether a clock distribution device should shut itself down because its reference clock has gone missing or has slowed below a usable rate. It runs on a free-running monitor clock, brings the reference into that domain, and counts the reference's rising edges over a fixed window of monitor cycles. A window with too few edges raises a power-down request, so a reference that has only drifted low is caught as well as one that has stopped. The request drops again only after the reference has been healthy for two windows in a row.

Detection runs only when the auto power-down enable is set and no output takes the reference clock directly. In either of the other cases the request is held low, so a device used as a plain fanout buffer, with its PLL switched off by the separate fanout control, can pass a reference as slow as DC without shutting down. The PLL shutdown output combines that fanout control with the power-down request.

Top module: `ref_loss_monitor`

## Requirements
- R1: While `rst_n` is low, `pd_req` is 0 and `pll_off` equals `fanout_mode`.
- R2: The block counts synchronized rising edges of `ref_clk` over windows of `WIN_LEN` (default 64) monitor cycles. A window passes when its edge count is greater than or equal to `thresh`.
- R3: While the monitor is active and not requesting power-down, one failing window sets `pd_req` to 1 in the cycle after that window closes.
- R4: Once `pd_req` is 1, it returns to 0 only after two back-to-back passing windows. After only one passing window it stays at 1.
- R5: The result of the first window after reset, or after the monitor becomes active again, is discarded. With a stopped reference, `pd_req` stays 0 for more than one window and rises when the second window closes.
- R6: When `apd_en` is 0, `pd_req` is 0 from the next cycle on, and the window timing restarts.
- R7: When `ref_direct` is 1, the monitor is blocked in the same way as with `apd_en` at 0: `pd_req` is 0 from the next cycle on.
- R8: `pll_off` is 1 whenever `fanout_mode` or `pd_req` is 1, and 0 otherwise, with no added cycle of delay.
- R9: When `thresh` is 0, every window passes and `pd_req` never rises, even with a stopped reference.
- R10: A reference that keeps toggling but gives fewer edges per window than `thresh` raises `pd_req`. It is treated the same as a stopped reference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_mon | input | 1 | Free-running monitor clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_clk | input | 1 | Reference clock under watch, asynchronous to clk_mon |
| apd_en | input | 1 | Auto power-down enable (1 = monitor on) |
| ref_direct | input | 1 | 1 when any output is sourced directly from the reference |
| fanout_mode | input | 1 | PLL power-down for fanout-buffer use |
| thresh | input | CNT_W | Minimum reference edges per window |
| pd_req | output | 1 | Device power-down request |
| pll_off | output | 1 | PLL shutdown |

## Verification
The checker watches every cycle for the following. A rise of the request must come from a failing window with a nonzero threshold. A fall while the monitor is active must come from a passing window. No request may appear before two windows have closed since the monitor became active. Either blocking input must clear the request on the next cycle, and the PLL shutdown must cover both of its causes. The bench scenarios show the actual frequency decision against a threshold. They also show the exact window count of the release hysteresis, the discarded first window after reset and after re-enabling, and the random mix of reference rates, thresholds and blocking flags.

// File: rtl/refmon_pkg.sv
// Shared types for the reference loss monitor.
package refmon_pkg;

    // Monitor decision states.
    // PRIME: the current window is being discarded.
    // RUN:   the reference is healthy.
    // DOWN:  power-down is requested.
    // REC:   power-down is requested and one passing window has been seen.
    typedef enum logic [1:0] {
        ST_PRIME = 2'd0,
        ST_RUN   = 2'd1,
        ST_DOWN  = 2'd2,
        ST_REC   = 2'd3
    } mon_state_t;

endpackage

// File: rtl/refmon_sync.sv
// Brings the asynchronous reference into the monitor clock domain.
// The first two flops form the synchronizer and the third delays the
// synchronized value for edge detection. rise_pulse lasts one cycle per
// reference rising edge.
// Assumes that the reference stays high and low for at least one monitor
// period each.
module refmon_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_mon,
    input  logic rst_n,
    input  logic ref_clk,
    output logic rise_pulse
);
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] pipe;

    // Shift the reference through the synchronizer and the edge-detect flop.
    always_ff @(posedge clk_mon) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= {pipe[DEPTH-2:0], ref_clk};
    end

    assign rise_pulse = pipe[DEPTH-2] & ~pipe[DEPTH-1];
endmodule

// File: rtl/refmon_window.sv
// Window timer and edge counter. When the monitor is active, it counts
// rise pulses over WIN_LEN cycles. In the last cycle of a window it raises
// win_done for one cycle, and win_ok reports whether the count, including
// that cycle's pulse, reached thresh. When the monitor is inactive, both
// counters are held at zero, so the next window starts fresh.
// Assumes that at most one rise pulse arrives every two cycles, so the
// edge count fits in CNT_W bits.
module refmon_window #(
    parameter int WIN_LEN = 64,
    parameter int CNT_W   = $clog2(WIN_LEN + 1)
) (
    input  logic             clk_mon,
    input  logic             rst_n,
    input  logic             active,
    input  logic             rise_pulse,
    input  logic [CNT_W-1:0] thresh,
    output logic             win_done,
    output logic             win_ok
);
    localparam int TW = $clog2(WIN_LEN);
    localparam logic [TW-1:0] LAST = TW'(WIN_LEN - 1);

    logic [TW-1:0]    tick;
    logic [CNT_W-1:0] edges;
    logic [CNT_W-1:0] total;

    assign total    = edges + CNT_W'(rise_pulse);
    assign win_done = active && (tick == LAST);
    assign win_ok   = (total >= thresh);

    // Advance the window timer and restart it at the end of each window.
    always_ff @(posedge clk_mon) begin
        if (!rst_n || !active) tick <= '0;
        else if (tick == LAST)  tick <= '0;
        else                    tick <= tick + 1'b1;
    end

    // Accumulate edges within the window and clear them when it closes.
    always_ff @(posedge clk_mon) begin
        if (!rst_n || !active) edges <= '0;
        else if (win_done)      edges <= '0;
        else                    edges <= total;
    end
endmodule

// File: rtl/refmon_fsm.sv
// Power-down decision with hysteresis. It discards the first window after
// the monitor becomes active, asserts on one failing window, and releases
// after two consecutive passing windows. When the monitor is inactive, it
// returns to the discard state and the request is cleared.
module refmon_fsm
    import refmon_pkg::*;
(
    input  logic clk_mon,
    input  logic rst_n,
    input  logic active,
    input  logic win_done,
    input  logic win_ok,
    output logic pd_req
);
    mon_state_t state, state_nx;

    // Next-state decision, taken only at window boundaries.
    always_comb begin
        state_nx = state;
        if (win_done) begin
            unique case (state)
                ST_PRIME: state_nx = ST_RUN;
                ST_RUN:   state_nx = win_ok ? ST_RUN : ST_DOWN;
                ST_DOWN:  state_nx = win_ok ? ST_REC : ST_DOWN;
                ST_REC:   state_nx = win_ok ? ST_RUN : ST_DOWN;
                default:  state_nx = ST_PRIME;
            endcase
        end
    end

    // State register. Reset or an inactive monitor returns it to discard.
    always_ff @(posedge clk_mon) begin
        if (!rst_n || !active) state <= ST_PRIME;
        else                   state <= state_nx;
    end

    assign pd_req = (state == ST_DOWN) || (state == ST_REC);
endmodule

// File: rtl/ref_loss_monitor.sv
// Top level of the reference loss power-down monitor. The monitor runs
// only when auto power-down is enabled and no output takes the reference
// directly. pll_off merges the fanout-mode PLL shutdown with the
// power-down request.
// Assumes that clk_mon runs at more than twice the highest reference
// frequency.
module ref_loss_monitor #(
    parameter int WIN_LEN     = 64,
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = $clog2(WIN_LEN + 1)
) (
    input  logic             clk_mon,
    input  logic             rst_n,
    input  logic             ref_clk,
    input  logic             apd_en,
    input  logic             ref_direct,
    input  logic             fanout_mode,
    input  logic [CNT_W-1:0] thresh,
    output logic             pd_req,
    output logic             pll_off
);
    logic mon_active;
    logic rise_pulse;
    logic win_done;
    logic win_ok;

    assign mon_active = apd_en & ~ref_direct;

    refmon_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_mon    (clk_mon),
        .rst_n      (rst_n),
        .ref_clk    (ref_clk),
        .rise_pulse (rise_pulse)
    );

    refmon_window #(.WIN_LEN(WIN_LEN), .CNT_W(CNT_W)) u_win (
        .clk_mon    (clk_mon),
        .rst_n      (rst_n),
        .active     (mon_active),
        .rise_pulse (rise_pulse),
        .thresh     (thresh),
        .win_done   (win_done),
        .win_ok     (win_ok)
    );

    refmon_fsm u_fsm (
        .clk_mon  (clk_mon),
        .rst_n    (rst_n),
        .active   (mon_active),
        .win_done (win_done),
        .win_ok   (win_ok),
        .pd_req   (pd_req)
    );

    assign pll_off = fanout_mode | pd_req;
endmodule

// File: rtl/refmon_checker.sv
// Protocol checker for ref_loss_monitor. It is bound to the top module and
// watches the ports together with the window signals that the window
// counter drives.
module refmon_checker #(
    parameter int CNT_W = 7
) (
    input logic             clk_mon,
    input logic             rst_n,
    input logic             apd_en,
    input logic             ref_direct,
    input logic             fanout_mode,
    input logic [CNT_W-1:0] thresh,
    input logic             pd_req,
    input logic             pll_off,
    input logic             mon_active,
    input logic             win_done,
    input logic             win_ok
);
    logic [1:0] closed;

    // Count closed windows since reset or since the monitor became active,
    // saturating at two.
    always_ff @(posedge clk_mon) begin
        if (!rst_n || !mon_active) closed <= '0;
        else if (win_done && closed != 2'd2) closed <= closed + 2'd1;
    end

    // R3: a new request must follow a failing window.
    a_r3_rise_on_fail: assert property (@(posedge clk_mon) disable iff (!rst_n)
        $rose(pd_req) |-> $past(win_done && !win_ok));

    // R4: a release while the monitor is active must follow a passing window.
    a_r4_fall_on_pass: assert property (@(posedge clk_mon) disable iff (!rst_n)
        ($fell(pd_req) && $past(mon_active)) |-> $past(win_done && win_ok));

    // R5: no request before two windows have closed.
    a_r5_first_discarded: assert property (@(posedge clk_mon) disable iff (!rst_n)
        pd_req |-> (closed == 2'd2));

    // R6: a disabled monitor clears the request.
    a_r6_disable_clears: assert property (@(posedge clk_mon) disable iff (!rst_n)
        !apd_en |=> !pd_req);

    // R7: a direct reference path blocks the monitor.
    a_r7_direct_blocks: assert property (@(posedge clk_mon) disable iff (!rst_n)
        ref_direct |=> !pd_req);

    // R8: both causes shut down the PLL.
    a_r8_pll_off_pd: assert property (@(posedge clk_mon) disable iff (!rst_n)
        pd_req |-> pll_off);
    a_r8_pll_off_fanout: assert property (@(posedge clk_mon) disable iff (!rst_n)
        fanout_mode |-> pll_off);

    // R9: a zero threshold never raises a request.
    a_r9_zero_thresh: assert property (@(posedge clk_mon) disable iff (!rst_n)
        $rose(pd_req) |-> ($past(thresh) != '0));
endmodule

bind ref_loss_monitor refmon_checker #(.CNT_W(CNT_W)) u_chk (
    .clk_mon     (clk_mon),
    .rst_n       (rst_n),
    .apd_en      (apd_en),
    .ref_direct  (ref_direct),
    .fanout_mode (fanout_mode),
    .thresh      (thresh),
    .pd_req      (pd_req),
    .pll_off     (pll_off),
    .mon_active  (mon_active),
    .win_done    (win_done),
    .win_ok      (win_ok)
);

// File: tb/tb_ref_loss_monitor.sv
module tb_ref_loss_monitor;
    localparam int WIN   = 64;
    localparam int CNT_W = $clog2(WIN + 1);

    logic clk_mon = 1'b0;
    logic rst_n = 1'b0;
    logic ref_clk = 1'b0;
    logic apd_en = 1'b1;
    logic ref_direct = 1'b0;
    logic fanout_mode = 1'b0;
    logic [CNT_W-1:0] thresh = '0;
    logic pd_req, pll_off;

    int n_checks = 0;
    int n_errors = 0;
    int ref_period = 0;   // in monitor cycles; 0 means the reference is stopped
    int ref_phase = 0;
    bit done = 1'b0;

    always #2.5 clk_mon = ~clk_mon;

    ref_loss_monitor dut (
        .clk_mon(clk_mon), .rst_n(rst_n), .ref_clk(ref_clk), .apd_en(apd_en),
        .ref_direct(ref_direct), .fanout_mode(fanout_mode), .thresh(thresh),
        .pd_req(pd_req), .pll_off(pll_off)
    );

    // Reference generator, updated on the falling monitor edge.
    always @(negedge clk_mon) begin
        if (ref_period == 0) begin
            ref_clk <= 1'b0;
            ref_phase <= 0;
        end else begin
            ref_clk <= (ref_phase < ref_period / 2);
            ref_phase <= (ref_phase + 1 >= ref_period) ? 0 : ref_phase + 1;
        end
    end

    task automatic check(input bit cond, input string req, input int act, input int exp);
        n_checks++;
        if (!cond) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk_mon);
        #1;
    endtask

    // Expected steady-state request from the requirements (R2, R6, R7, R9, R10).
    function automatic bit exp_pd(input int per, input int th, input bit en, input bit dir);
        int edges;
        edges = (per == 0) ? 0 : WIN / per;
        return en && !dir && (edges < th);
    endfunction

    function automatic bit near_limit(input int per, input int th);
        int edges;
        edges = (per == 0) ? 0 : WIN / per;
        return (th != 0) && (edges - th <= 2) && (th - edges <= 2);
    endfunction

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        int p, th;
        bit en, dir, fo, e;
        void'($urandom(32'd7321));
        // R1: reset state
        thresh = CNT_W'(5);
        fanout_mode = 1'b1;
        cyc(3);
        check(pd_req == 0, "R1", pd_req, 0);
        check(pll_off == 1, "R1", pll_off, 1);
        fanout_mode = 1'b0;
        #1;
        check(pll_off == 0, "R1", pll_off, 0);
        rst_n = 1'b1;
        // R5: first window discarded, request at end of the second (stopped reference)
        cyc(100);
        check(pd_req == 0, "R5", pd_req, 0);
        cyc(40);
        check(pd_req == 1, "R5", pd_req, 1);
        // R8: pll_off follows pd_req
        check(pll_off == 1, "R8", pll_off, 1);

        // R4: release needs two passing windows
        thresh = CNT_W'(10);
        ref_period = 3;
        cyc(6 * WIN);
        check(pd_req == 0, "R2", pd_req, 0);
        ref_period = 0;
        begin
            int guard;
            guard = 0;
            while (!pd_req && guard < 4 * WIN) begin cyc(1); guard++; end
        end
        check(pd_req == 1, "R3", pd_req, 1);
        ref_period = 3;
        cyc(100);
        check(pd_req == 1, "R4", pd_req, 1);
        cyc(40);
        check(pd_req == 0, "R4", pd_req, 0);

        // R10: slow but running reference (4 edges per window, threshold 8)
        thresh = CNT_W'(8);
        ref_period = 16;
        cyc(6 * WIN);
        check(pd_req == 1, "R10", pd_req, 1);

        // R6: disabling clears the request on the next cycle
        apd_en = 1'b0;
        cyc(1);
        check(pd_req == 0, "R6", pd_req, 0);
        cyc(4 * WIN);
        check(pd_req == 0, "R6", pd_req, 0);
        // R5: re-enable discards the first window again
        apd_en = 1'b1;
        cyc(100);
        check(pd_req == 0, "R5", pd_req, 0);
        cyc(40);
        check(pd_req == 1, "R5", pd_req, 1);

        // R7: direct reference path blocks the monitor
        ref_direct = 1'b1;
        cyc(1);
        check(pd_req == 0, "R7", pd_req, 0);
        cyc(4 * WIN);
        check(pd_req == 0, "R7", pd_req, 0);
        ref_direct = 1'b0;

        // R9: zero threshold with a stopped reference
        thresh = '0;
        ref_period = 0;
        cyc(6 * WIN);
        check(pd_req == 0, "R9", pd_req, 0);

        // R8: fanout mode with the monitor off, reference at DC
        apd_en = 1'b0;
        fanout_mode = 1'b1;
        #1;
        check(pll_off == 1, "R8", pll_off, 1);
        cyc(3 * WIN);
        check(pd_req == 0, "R8", pd_req, 0);
        fanout_mode = 1'b0;
        #1;
        check(pll_off == 0, "R8", pll_off, 0);

        // Random mix of rates, thresholds and blocking flags (R2, R3, R6, R7, R10)
        for (int i = 0; i < 24; i++) begin
            do begin
                p  = ($urandom_range(0, 5) == 0) ? 0 : int'($urandom_range(3, 20));
                th = int'($urandom_range(0, 30));
            end while (near_limit(p, th));
            en  = ($urandom_range(0, 4) != 0);
            dir = ($urandom_range(0, 5) == 0);
            fo  = $urandom_range(0, 1);
            ref_period = p;
            thresh = CNT_W'(th);
            apd_en = en;
            ref_direct = dir;
            fanout_mode = fo;
            cyc(6 * WIN);
            e = exp_pd(p, th, en, dir);
            check(pd_req == e, "R2", pd_req, e);
            check(pll_off == (e | fo), "R8", pll_off, e | fo);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule